// File: doc/BRIEF.md
# Fuse Value Serial Readback Register

This block serves the read path of a one-wire trim interface. When the command decoder recognizes a read request, it presents the stored fuse value of the selected parameter together with the number of bits that parameter really uses. The block captures that value in a shift register. Unused upper positions are forced to zero. The block then raises a read-active flag that steers the shared output pin from the analog path to the digital bit stream. The register MSB is visible on the data output from the first cycle.

Each falling-edge strobe from the pulse decoder advances the register by one position, so the next lower bit appears on the output. Once the LSB has been shown, one more strobe ends read mode, releases the pin and drives the data output low. Strobes that arrive outside read mode do nothing. A new load during a read starts the sequence again from the top with the new value.

Top module: `fuse_rdbk_top`

## Requirements
- R1: After reset, rd_active_o is 0 and data_o is 0.
- R2: In the cycle after load_i is high, rd_active_o is 1 and data_o carries bit 7 of the padded value, before any strobe.
- R3: load_len_i gives the number of valid low-order bits of load_val_i. The values 1 to 7 keep that many LSBs and force every higher bit to zero. The values 0 and 8 or more keep all 8 bits.
- R4: While read mode is active, the k-th fall_i strobe (k = 1..7) makes data_o show bit 7-k of the padded value in the following cycle, so the 7th strobe presents the LSB.
- R5: The 8th fall_i strobe after a load clears rd_active_o, and data_o reads 0 from then on.
- R6: fall_i strobes while rd_active_o is 0 change neither output.
- R7: A load_i during an active read restarts the sequence with the new value. The MSB shows at once, and 7 further strobes present the LSB.
- R8: When load_i and fall_i are high in the same cycle, the load wins and no shift takes place.
- R9: While read mode is active and neither strobe is high, data_o and the pulse count stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | One-cycle strobe: enter read mode with load_val_i |
| load_val_i | input | 8 | Stored fuse value of the selected parameter |
| load_len_i | input | 4 | Valid bit count of the parameter (0 means all) |
| fall_i | input | 1 | One-cycle strobe for each falling edge of the programming input |
| data_o | output | 1 | Serial read bit, 0 when read mode is inactive |
| rd_active_o | output | 1 | High while the digital stream owns the output pin |

## Verification
The properties assume that load_i and fall_i are single-cycle strobes that are already synchronous to clk_i. They also assume that load_val_i and load_len_i are valid in the cycle the load strobe is high. The bench drives every strobe for exactly one clock from the falling clock edge and holds both operands steady across the load. Between strobes it leaves idle cycles, so the hold behaviour is exercised next to every shift.

// File: rtl/fuse_rdbk_pkg.sv
package fuse_rdbk_pkg;
  localparam int RDBK_W = 8;

  // Valid-bit count after mapping 0 and oversized values to full width
  function automatic int unsigned eff_len(input int unsigned len, input int unsigned w);
    return (len == 0 || len > w) ? w : len;
  endfunction
endpackage

// File: rtl/rdbk_pad.sv
module rdbk_pad #(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 4
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [DATA_W-1:0] pad_o
);
  int unsigned keep;
  always_comb keep = fuse_rdbk_pkg::eff_len(32'(len_i), DATA_W);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign pad_o[i] = (i < keep) ? val_i[i] : 1'b0;
  end
endmodule

// File: rtl/rdbk_ctr.sv
module rdbk_ctr #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             fall_i,
  output logic             active_o,
  output logic             shift_o,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic             act_q;
  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step     = act_q & fall_i & ~load_i;
  assign shift_o  = step & (cnt_q != LAST);
  assign done_o   = step & (cnt_q == LAST);
  assign active_o = act_q;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (load_i) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) act_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rdbk_shreg.sv
module rdbk_shreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic              shift_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] sreg_o
);
  logic [DATA_W-1:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sreg_q <= '0;
    else if (load_i)  sreg_q <= load_val_i;
    else if (clr_i)   sreg_q <= '0;
    else if (shift_i) sreg_q <= {sreg_q[DATA_W-2:0], 1'b0};
  end

  assign sreg_o = sreg_q;
endmodule

// File: rtl/fuse_rdbk_top.sv
module fuse_rdbk_top #(
  parameter int DATA_W = fuse_rdbk_pkg::RDBK_W,
  localparam int LEN_W = $clog2(DATA_W + 1),
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic [LEN_W-1:0]  load_len_i,
  input  logic              fall_i,
  output logic              data_o,
  output logic              rd_active_o
);
  logic [DATA_W-1:0] padded;
  logic [DATA_W-1:0] sreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              active, shift, done;

  rdbk_pad #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_pad (
    .val_i (load_val_i),
    .len_i (load_len_i),
    .pad_o (padded)
  );

  rdbk_ctr #(.DATA_W(DATA_W)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_i),
    .fall_i   (fall_i),
    .active_o (active),
    .shift_o  (shift),
    .done_o   (done),
    .cnt_o    (cnt_q)
  );

  rdbk_shreg #(.DATA_W(DATA_W)) u_sreg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .load_val_i (padded),
    .shift_i    (shift),
    .clr_i      (done),
    .sreg_o     (sreg_q)
  );

  // Pin owned by digital stream only while reading
  assign data_o      = active & sreg_q[DATA_W-1];
  assign rd_active_o = active;
endmodule

// File: rtl/fuse_rdbk_chk.sv
module fuse_rdbk_chk #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic              fall_i,
  input logic              data_o,
  input logic              rd_active_o,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [DATA_W-1:0] sreg_q
);
  // R2
  load_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> rd_active_o && cnt_q == '0);

  // R4
  shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_active_o && fall_i && !load_i && cnt_q < CNT_W'(DATA_W - 1)
    |=> data_o == $past(sreg_q[DATA_W-2]) && cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  // R5
  end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_active_o && fall_i && !load_i && cnt_q == CNT_W'(DATA_W - 1)
    |=> !rd_active_o && !data_o);

  // R6
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_active_o && !load_i |=> !rd_active_o && !data_o);

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_active_o && !fall_i && !load_i |=> $stable(data_o) && $stable(cnt_q));

  // R8
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && fall_i |=> cnt_q == '0 && rd_active_o);

  // R5
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DATA_W));
endmodule

bind fuse_rdbk_top fuse_rdbk_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .load_i      (load_i),
  .fall_i      (fall_i),
  .data_o      (data_o),
  .rd_active_o (rd_active_o),
  .cnt_q       (cnt_q),
  .sreg_q      (sreg_q)
);

// File: tb/fuse_rdbk_top_tb_top.sv
module fuse_rdbk_top_tb_top;
  localparam int W = 8;
  localparam int NV = 6;
  // {value[11:4], len[3:0]}
  localparam logic [11:0] VEC [NV] = '{
    {8'hA5, 4'd8}, {8'hFF, 4'd3}, {8'h5C, 4'd0},
    {8'h81, 4'd7}, {8'h00, 4'd8}, {8'hFF, 4'd1}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       load_i = 1'b0;
  logic [7:0] load_val_i = '0;
  logic [3:0] load_len_i = '0;
  logic       fall_i = 1'b0;
  logic       data_o, rd_active_o;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  fuse_rdbk_top dut_i (.*);

  function automatic logic [7:0] pad(input logic [7:0] v, input int l);
    logic [7:0] r = v;
    if (l != 0 && l < 8)
      for (int i = l; i < 8; i++) r[i] = 1'b0;
    return r;
  endfunction

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic do_load(input logic [7:0] v, input logic [3:0] l, input logic f);
    @(negedge clk_i);
    load_i = 1'b1; load_val_i = v; load_len_i = l; fall_i = f;
    @(negedge clk_i);
    load_i = 1'b0; fall_i = 1'b0;
  endtask

  task automatic do_fall();
    @(negedge clk_i); fall_i = 1'b1;
    @(negedge clk_i); fall_i = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] e;
    repeat (3) @(negedge clk_i);
    chk("R1 active", rd_active_o, 1'b0);
    chk("R1 data", data_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R6: strobes while idle are ignored
    do_fall(); do_fall();
    chk("R6 active", rd_active_o, 1'b0);
    chk("R6 data", data_o, 1'b0);

    // R2 R3 R4 R5 over the vector table
    for (int v = 0; v < NV; v++) begin
      e = pad(VEC[v][11:4], int'(VEC[v][3:0]));
      do_load(VEC[v][11:4], VEC[v][3:0], 1'b0);
      chk("R2 active", rd_active_o, 1'b1);
      chk("R2 R3 msb", data_o, e[7]);
      for (int k = 1; k < 8; k++) begin
        do_fall();
        chk("R4 R3 bit", data_o, e[7-k]);
      end
      do_fall();
      chk("R5 active", rd_active_o, 1'b0);
      chk("R5 data", data_o, 1'b0);
    end

    // R9: hold with no strobe
    do_load(8'b1010_0000, 4'd8, 1'b0);
    do_fall();
    repeat (4) @(negedge clk_i);
    chk("R9 hold", data_o, 1'b0);
    do_fall();
    chk("R9 next", data_o, 1'b1);

    // R7: restart mid-read
    do_load(8'h80, 4'd8, 1'b0);
    do_fall(); do_fall(); do_fall();
    do_load(8'h7F, 4'd8, 1'b0);
    chk("R7 msb", data_o, 1'b0);
    for (int k = 1; k < 8; k++) do_fall();
    chk("R7 lsb", data_o, 1'b1);
    chk("R7 still active", rd_active_o, 1'b1);
    do_fall();
    chk("R7 end", rd_active_o, 1'b0);

    // R8: load and fall together, load wins, no shift
    do_load(8'hC0, 4'd8, 1'b0);
    do_fall(); do_fall();
    do_load(8'h80, 4'd8, 1'b1);
    chk("R8 msb", data_o, 1'b1);
    do_fall();
    chk("R8 first shift", data_o, 1'b0);
    for (int k = 2; k < 8; k++) do_fall();
    chk("R8 active", rd_active_o, 1'b1);
    do_fall();
    chk("R8 end", rd_active_o, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule